// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits between an I2C bus engine and the host register file. The bus engine sends it a single-cycle strobe for each of seven events: arbitration lost, NACK received, access ready, receive data ready, transmit ready, stop detected and addressed as slave. The unit latches each strobe as a sticky flag. A mask register selects which flags may interrupt the host. A priority encoder turns the pending, enabled flags into a small vector code. When the host reads that code, the flag it names is acknowledged. An interrupt service routine can therefore read the vector register over and over, handle one event per read, and stop when the read returns zero.

The host reaches three registers through a simple strobed port. The port has a 2-bit select, a write strobe and a read strobe. Read data is registered and held until the next read. The status register also shows two live bus levels: bus busy and receive shift full. These two bits are for reporting only and never take part in interrupts.

The interrupt request output comes from a two-state machine. In state `IRQ_QUIET` no enabled flag is pending. In state `IRQ_RAISED` at least one enabled flag is pending. Transition RAISE (`IRQ_QUIET` to `IRQ_RAISED`) is taken when the next-cycle flags ANDed with the next-cycle mask become nonzero. Transition DROP (`IRQ_RAISED` to `IRQ_QUIET`) is taken when that product becomes zero. Because the machine is driven by next-cycle values, the output changes on the same edge as the flags and mask that cause it.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset all flags and the mask are zero, the interrupt request is low, and read data is zero.
- R2: An event strobe sets its flag on the next clock edge. Flag and mask bit positions are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: Writing the status register (select 0) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A strobe in the same cycle as a clear of the same flag leaves the flag set.
- R4: The mask register (select 1) stores write data bits 6:0 and reads them back. Its upper bits read 0.
- R5: The vector register (select 2) returns the code of the pending enabled event with the lowest bit position, code = bit position + 1. Arbitration lost (code 1) therefore wins over all other events.
- R6: The vector register returns 0 when no enabled flag is pending. Flags whose mask bit is 0 are ignored.
- R7: A vector read clears the flag it reports, so the next read returns the next pending code. Masked flags stay set. A strobe of the reported event in the same cycle keeps its flag set.
- R8: The interrupt request is high exactly when the flags ANDed with the mask are nonzero.
- R9: Status bit 11 shows the receive-shift-full level and bit 12 shows the bus-busy level. Bits 10:7 and 15:13 read 0. Neither level ever yields a vector code or an interrupt.
- R10: Read data is loaded on the edge where the read strobe is high and holds between reads. Writes to the vector register and to select 3 have no effect, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | Event strobes, bit order as in R2 |
| bus_busy_i | input | 1 | Live bus-busy level |
| rx_full_i | input | 1 | Live receive-shift-full level |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 vector, 3 none |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the collisions. One is a vector read that acknowledges a flag in the same cycle as a new strobe of that same event. The other is a status write that clears a flag in the same cycle as its strobe. The bench drives the strobe and the register access on the same falling edge, so both land on one rising edge, and then reads the register back. Apart from those cases, the bench sweeps all 128 flag patterns against several masks. For each one it drains the vector register until it reads zero and compares every code with the lowest-set-bit order computed in the bench.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
    parameter int NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] w1c_i,
    input  logic [NUM_EVT-1:0] ack_i,
    output logic [NUM_EVT-1:0] flag_q,
    output logic [NUM_EVT-1:0] flag_nxt
);

    // One sticky bit per event; a new strobe outranks any clear.
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        assign flag_nxt[g] = evt_i[g] | (flag_q[g] & ~w1c_i[g] & ~ack_i[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else begin
                flag_q[g] <= flag_nxt[g];
            end
        end
    end

endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
    parameter int NUM_EVT = 7,
    parameter int CODE_W  = 3
) (
    input  logic [NUM_EVT-1:0] req_i,
    output logic [CODE_W-1:0]  code_o,
    output logic [NUM_EVT-1:0] onehot_o
);

    // Scan from the top down so the lowest requesting bit is the last hit.
    always_comb begin
        code_o   = '0;
        onehot_o = '0;
        for (int k = NUM_EVT - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                code_o      = CODE_W'(k + 1);
                onehot_o    = '0;
                onehot_o[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_irq_fsm.sv
module i2c_irq_fsm
    import i2c_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_nxt_i)  state_d = IRQ_RAISED;  // RAISE
            IRQ_RAISED: if (!pend_nxt_i) state_d = IRQ_QUIET;   // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
    import i2c_irq_pkg::*;
#(
    parameter int NUM_EVT = 7,
    parameter int DATA_W  = 16,
    parameter int RXF_BIT = 11,
    parameter int BB_BIT  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               bus_busy_i,
    input  logic               rx_full_i,
    input  logic [1:0]         reg_sel_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    localparam int CODE_W = $clog2(NUM_EVT + 1);

    reg_sel_e           sel;
    logic [NUM_EVT-1:0] flag_q, flag_nxt;
    logic [NUM_EVT-1:0] mask_q, mask_nxt;
    logic [NUM_EVT-1:0] w1c, ack, ack_oh, pend;
    logic [CODE_W-1:0]  vec_code;
    logic [DATA_W-1:0]  status_word, rd_mux;

    assign sel = reg_sel_e'(reg_sel_i);

    assign w1c      = (wr_en_i && sel == SEL_STATUS) ? wdata_i[NUM_EVT-1:0] : '0;
    assign mask_nxt = (wr_en_i && sel == SEL_MASK)   ? wdata_i[NUM_EVT-1:0] : mask_q;
    assign pend     = flag_q & mask_q;
    assign ack      = (rd_en_i && sel == SEL_VECTOR) ? ack_oh : '0;

    i2c_irq_flags #(.NUM_EVT(NUM_EVT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .w1c_i    (w1c),
        .ack_i    (ack),
        .flag_q   (flag_q),
        .flag_nxt (flag_nxt)
    );

    i2c_irq_prio #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_prio (
        .req_i    (pend),
        .code_o   (vec_code),
        .onehot_o (ack_oh)
    );

    i2c_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_nxt_i (|(flag_nxt & mask_nxt)),
        .irq_o      (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_nxt;
        end
    end

    always_comb begin
        status_word              = '0;
        status_word[NUM_EVT-1:0] = flag_q;
        status_word[RXF_BIT]     = rx_full_i;
        status_word[BB_BIT]      = bus_busy_i;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status_word;
            SEL_MASK:   rd_mux = DATA_W'(mask_q);
            SEL_VECTOR: rd_mux = DATA_W'(vec_code);
            SEL_NONE:   rd_mux = '0;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/i2c_irq_vector_chk.sv
module i2c_irq_vector_chk #(
    parameter int NUM_EVT = 7,
    parameter int CODE_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic [NUM_EVT-1:0] flags,
    input logic [NUM_EVT-1:0] mask,
    input logic [CODE_W-1:0]  code,
    input logic               irq
);

    AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(flags & mask))); // R8

    AST_QUIET_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> code == '0); // R6

    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (code != '0 && code <= CODE_W'(NUM_EVT))); // R5

    AST_ARB_LOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && mask[0]) |-> code == CODE_W'(1)); // R5

    AST_STROBE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i))); // R2

endmodule

bind i2c_irq_vector i2c_irq_vector_chk #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .flags (flag_q),
    .mask  (mask_q),
    .code  (vec_code),
    .irq   (irq_o)
);

// File: tb/tb_i2c_irq_vector.sv
module tb_i2c_irq_vector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        bb = 1'b0;
    logic        rxf = 1'b0;
    logic [1:0]  sel = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_irq_vector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .bus_busy_i (bb),
        .rx_full_i  (rxf),
        .reg_sel_i  (sel),
        .wr_en_i    (wr),
        .rd_en_i    (rd),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        sel = s; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [6:0] p);
        @(negedge clk);
        evt = p;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic logic [15:0] status_exp(input logic [6:0] f, input logic b, input logic r);
        logic [15:0] v;
        v = '0;
        v[6:0] = f;
        v[11] = r;
        v[12] = b;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [6:0]  masks [5];
        masks[0] = 7'h7F; masks[1] = 7'h00; masks[2] = 7'h55;
        masks[3] = 7'h2A; masks[4] = 7'h1C;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", rdata, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
        rst_n = 1'b1;
        reg_read(2'd0, d); chk("R1 status", d, 16'h0);
        reg_read(2'd1, d); chk("R1 mask", d, 16'h0);
        reg_read(2'd2, d); chk("R1 vector", d, 16'h0);

        // R4: mask upper bits dropped
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, d); chk("R4 mask readback", d, 16'h007F);

        // R3: write-one-to-clear, write zero no effect
        pulse(7'h24);
        reg_read(2'd0, d); chk("R2 status after strobe", d, 16'h0024);
        reg_write(2'd0, 16'h0004);
        reg_read(2'd0, d); chk("R3 clear access ready", d, 16'h0020);
        reg_write(2'd0, 16'h0000);
        reg_read(2'd0, d); chk("R3 write zero", d, 16'h0020);
        // R3: strobe and clear collide on bit 5
        @(negedge clk);
        sel = 2'd0; wdata = 16'h0020; wr = 1'b1; evt = 7'h20;
        @(negedge clk);
        wr = 1'b0; evt = '0;
        reg_read(2'd0, d); chk("R3 strobe beats clear", d, 16'h0020);

        // R10: writes to vector and select 3 ignored; rdata holds
        reg_write(2'd2, 16'h0020);
        reg_write(2'd3, 16'h007F);
        reg_read(2'd0, d); chk("R10 ignored writes", d, 16'h0020);
        reg_read(2'd3, d); chk("R10 select 3 reads zero", d, 16'h0000);
        reg_read(2'd0, d);
        repeat (3) @(negedge clk);
        chk("R10 rdata holds", rdata, 16'h0020);

        // R7: vector read collides with strobe of reported event
        @(negedge clk);
        sel = 2'd2; rd = 1'b1; evt = 7'h20;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        chk("R7 vector code", rdata, 16'd6);
        reg_read(2'd0, d); chk("R7 strobe keeps flag", d, 16'h0020);
        reg_write(2'd0, 16'h007F);
        chk("R8 irq low after clear", {15'h0, irq}, 16'h0);

        // Sweep: all flag patterns against several masks
        for (int mi = 0; mi < 5; mi++) begin
            for (int p = 0; p < 128; p++) begin
                logic [6:0] rem;
                logic [6:0] m;
                m = masks[mi];
                rem = 7'(p);
                bb = rem[0];
                rxf = rem[1];
                reg_write(2'd1, {9'h0, m});
                pulse(rem);
                // R2 / R9: status layout and live levels
                reg_read(2'd0, d); chk("R2 R9 status", d, status_exp(rem, bb, rxf));
                chk("R8 irq", {15'h0, irq}, {15'h0, |(rem & m)});
                // R5 / R7: drain in lowest-bit order
                for (int n = 0; n < 7; n++) begin
                    if ((rem & m) != 0) begin
                        int low;
                        low = 0;
                        for (int k = 6; k >= 0; k--) if (rem[k] && m[k]) low = k;
                        reg_read(2'd2, d); chk("R5 R7 vector", d, 16'(low + 1));
                        rem[low] = 1'b0;
                    end
                end
                // R6 / R9: nothing enabled left
                reg_read(2'd2, d); chk("R6 R9 vector zero", d, 16'h0);
                chk("R8 R9 irq low", {15'h0, irq}, 16'h0);
                reg_read(2'd0, d); chk("R7 masked flags kept", d, status_exp(rem, bb, rxf));
                reg_write(2'd0, 16'h007F);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule